// File: doc/BRIEF.md
# Start-of-Frame Synchronization Detector for Type B Tag Responses

This block sits on the reader's receive path, behind a correlator that delivers one soft-decision sign per sample at two samples per elementary time unit (ETU). A sign of 1 means positive correlation, which is logic high. A sign of 0 means negative correlation, which is logic low. The block finds the start-of-frame pattern that a tag sends before its first character, and tells a downstream character assembler when to begin.

After the first high sample, the detector enters a synchronization wait of bounded length. It then measures a low phase against a minimum and a maximum length, and a short high phase against a maximum length. A falling edge after that high phase marks the first start bit. The detector answers that edge with a one-cycle sync pulse. Any timing violation gives a one-cycle error pulse, clears the run counter and returns the detector to its idle, unsynchronized state. The run counter saturates rather than wraps.

Samples arrive on a valid/ready stream. The detector never applies back-pressure: `s_ready` is low only during reset and is high from the first clock edge after reset. A sample is taken on each rising edge where `s_valid` and `s_ready` are both high. Cycles without a valid sample are not counted. The sync and error pulses are plain control outputs with no handshake, so the consumer must sample them on every cycle.

Top module: `sof_sync_detector`

## Requirements
- R1: In reset and on the first cycle after it, `sync_o`, `err_o` and `busy_o` are 0. `s_ready` is 0 while `rst_n` is low and 1 from the first clock edge after reset is released.
- R2: A cycle with `s_valid` low changes neither the state nor the run count. The outcome of a sample sequence is the same whether or not idle cycles are inserted between samples.
- R3: While idle (`busy_o` = 0), negative samples (sign 0) are ignored and give no pulse. A positive sample (sign 1) makes `busy_o` 1 from the next cycle and starts the synchronization wait, counting that sample as the first.
- R4: The synchronization wait accepts at most 52 positive samples (26 ETU). A 53rd consecutive positive sample gives `err_o` = 1 for one cycle and sets `busy_o` to 0, both from the next cycle.
- R5: A negative sample during the wait starts the low phase and is its first sample. If a positive sample ends the low phase after fewer than 16 low samples, that positive sample gives an error pulse and a return to idle.
- R6: A 29th consecutive low sample (more than 14 ETU) gives an error pulse and a return to idle.
- R7: A positive sample that ends a low phase of 16 to 28 samples starts the high phase and is its first sample. A 5th consecutive high sample (more than 2 ETU) gives an error pulse and a return to idle.
- R8: A negative sample after a high phase of 1 to 4 samples gives `sync_o` = 1 for exactly one cycle, on the next cycle, and returns the detector to idle (`busy_o` = 0 on that same cycle).
- R9: `sync_o` and `err_o` are never high together, and neither stays high for two cycles in a row.
- R10: After an error the run counter is cleared. A valid frame that starts on the very next sample is accepted with the same limits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | A sample is present on `s_sign` |
| s_ready | output | 1 | Detector accepts samples; high whenever out of reset |
| s_sign | input | 1 | Sign of the soft decision: 1 positive (high), 0 negative (low) |
| sync_o | output | 1 | One-cycle pulse: a valid start-of-frame ended at the first start bit |
| err_o | output | 1 | One-cycle pulse: a timing window was violated, detector back to idle |
| busy_o | output | 1 | Detector is inside a start-of-frame attempt |

## Verification
Two functions can fall on the same sample: the edge that ends a phase, and the length check of that phase. The edge that ends a low phase is also the point where the minimum-length test is judged. The sample that would extend a run is also the point where the maximum limit is reached. The bench provokes each case by sweeping the synchronization wait from 1 to 53 samples, the low phase from 1 to 30 samples and the high phase from 1 to 6 samples, with and without idle cycles between samples. For every sample it computes arithmetically whether a sync pulse, an error pulse or neither must appear on the next cycle, and what `busy_o` must be.

// File: rtl/sof_pkg.sv
package sof_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_LOW  = 2'd2,
    ST_HIGH = 2'd3
  } sof_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sof_run_counter.sv
module sof_run_counter #(
  parameter int CMAX = 52,
  localparam int CW = $clog2(CMAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load1,
  input  logic          inc,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] TOP = CW'(CMAX);

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt <= '0;
    else if (clr)       cnt <= '0;
    else if (load1)     cnt <= CW'(1);
    else if (inc && cnt != TOP) cnt <= cnt + CW'(1);
  end

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= TOP);

  // R4
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && !load1 && cnt == TOP) |=> (cnt == TOP));
endmodule

// File: rtl/sof_limit_cmp.sv
module sof_limit_cmp #(
  parameter int CW        = 6,
  parameter int WAIT_LIM  = 52,
  parameter int LOW_MIN   = 16,
  parameter int LOW_LIM   = 28,
  parameter int HIGH_LIM  = 4
) (
  input  logic [CW-1:0] cnt,
  output logic          wait_full,
  output logic          low_short,
  output logic          low_full,
  output logic          high_full
);
  always_comb begin
    wait_full = (cnt >= CW'(WAIT_LIM));
    low_short = (cnt <  CW'(LOW_MIN));
    low_full  = (cnt >= CW'(LOW_LIM));
    high_full = (cnt >= CW'(HIGH_LIM));
  end
endmodule

// File: rtl/sof_sync_detector.sv
module sof_sync_detector
  import sof_pkg::*;
#(
  parameter int SMP_PER_ETU   = 2,
  parameter int WAIT_MAX_ETU  = 26,
  parameter int LOW_MIN_ETU   = 8,
  parameter int LOW_MAX_ETU   = 14,
  parameter int HIGH_MAX_ETU  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic s_valid,
  output logic s_ready,
  input  logic s_sign,
  output logic sync_o,
  output logic err_o,
  output logic busy_o
);
  localparam int WAIT_LIM = WAIT_MAX_ETU * SMP_PER_ETU;
  localparam int LOW_MIN  = LOW_MIN_ETU  * SMP_PER_ETU;
  localparam int LOW_LIM  = LOW_MAX_ETU  * SMP_PER_ETU;
  localparam int HIGH_LIM = HIGH_MAX_ETU * SMP_PER_ETU;
  localparam int CMAX     = max2(max2(WAIT_LIM, LOW_LIM), HIGH_LIM);
  localparam int CW       = $clog2(CMAX + 1);

  sof_state_e state, nxt_state;
  logic [CW-1:0] cnt;
  logic clr, load1, inc, set_err, set_sync, take;
  logic wait_full, low_short, low_full, high_full;
  logic ready_q;

  assign take    = s_valid && ready_q;
  assign s_ready = ready_q;
  assign busy_o  = (state != ST_IDLE);

  sof_run_counter #(.CMAX(CMAX)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load1(load1), .inc(inc), .cnt(cnt)
  );

  sof_limit_cmp #(
    .CW(CW), .WAIT_LIM(WAIT_LIM), .LOW_MIN(LOW_MIN),
    .LOW_LIM(LOW_LIM), .HIGH_LIM(HIGH_LIM)
  ) u_cmp (
    .cnt(cnt), .wait_full(wait_full), .low_short(low_short),
    .low_full(low_full), .high_full(high_full)
  );

  always_comb begin
    nxt_state = state;
    clr = 1'b0; load1 = 1'b0; inc = 1'b0;
    set_err = 1'b0; set_sync = 1'b0;
    if (take) begin
      unique case (state)
        ST_IDLE: if (s_sign) begin
          nxt_state = ST_WAIT; load1 = 1'b1;
        end
        ST_WAIT: if (s_sign) begin
          if (wait_full) set_err = 1'b1; else inc = 1'b1;
        end else begin
          nxt_state = ST_LOW; load1 = 1'b1;
        end
        ST_LOW: if (!s_sign) begin
          if (low_full) set_err = 1'b1; else inc = 1'b1;
        end else begin
          if (low_short) set_err = 1'b1;
          else begin nxt_state = ST_HIGH; load1 = 1'b1; end
        end
        ST_HIGH: if (s_sign) begin
          if (high_full) set_err = 1'b1; else inc = 1'b1;
        end else begin
          set_sync = 1'b1; nxt_state = ST_IDLE; clr = 1'b1;
        end
        default: nxt_state = ST_IDLE;
      endcase
    end
    if (set_err) begin
      nxt_state = ST_IDLE; clr = 1'b1; load1 = 1'b0; inc = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      sync_o  <= 1'b0;
      err_o   <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      state   <= nxt_state;
      sync_o  <= set_sync;
      err_o   <= set_err;
      ready_q <= 1'b1;
    end
  end

  // R9
  no_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sync_o && err_o));

  // R9
  sync_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o |=> !sync_o);

  // R9
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);

  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s_valid |=> ($stable(state) && $stable(cnt)));

  // R8
  sync_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o |-> ($past(s_valid) && !$past(s_sign) && !busy_o));

  // R3
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ($past(s_valid) && $past(s_sign)));

  // R4
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!busy_o && cnt == '0));
endmodule

// File: tb/sof_sync_detector_test.sv
`timescale 1ns/1ps
module sof_sync_detector_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0;
  logic s_sign = 1'b0;
  logic s_ready, sync_o, err_o, busy_o;
  int n_chk = 0;
  int n_bad = 0;
  bit gaps = 1'b0;

  always #10 clk = ~clk;

  sof_sync_detector uut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_sign(s_sign), .sync_o(sync_o), .err_o(err_o), .busy_o(busy_o)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // One sample; outputs checked one cycle later against expectations.
  task automatic send(input logic sg, input logic e_sync, input logic e_err,
                      input logic e_busy, input string tag);
    if (gaps) begin
      @(negedge clk);
      s_valid = 1'b0; s_sign = ~sg;
      @(posedge clk); #1;
      check({tag, " R2 gap sync"}, sync_o, 1'b0);
      check({tag, " R2 gap err"}, err_o, 1'b0);
    end
    @(negedge clk);
    s_valid = 1'b1; s_sign = sg;
    @(posedge clk); #1;
    s_valid = 1'b0;
    check({tag, " sync"}, sync_o, e_sync);
    check({tag, " err"}, err_o, e_err);
    check({tag, " busy"}, busy_o, e_busy);
  endtask

  // Frame: wait run w (positive), low run l, high run h, then a falling edge.
  task automatic frame(input int w, input int l, input int h);
    for (int i = 1; i <= 2; i++) send(1'b0, 1'b0, 1'b0, 1'b0, "R3 idle neg");
    for (int i = 1; i <= w; i++) begin
      if (i == 53) begin send(1'b1, 1'b0, 1'b1, 1'b0, "R4 wait limit"); return; end
      send(1'b1, 1'b0, 1'b0, 1'b1, "R3/R4 wait");
    end
    for (int i = 1; i <= l; i++) begin
      if (i == 29) begin send(1'b0, 1'b0, 1'b1, 1'b0, "R6 low too long"); return; end
      send(1'b0, 1'b0, 1'b0, 1'b1, "R5 low");
    end
    if (l < 16) begin send(1'b1, 1'b0, 1'b1, 1'b0, "R5 low too short"); return; end
    for (int i = 1; i <= h; i++) begin
      if (i == 5) begin send(1'b1, 1'b0, 1'b1, 1'b0, "R7 high too long"); return; end
      send(1'b1, 1'b0, 1'b0, 1'b1, "R7 high");
    end
    send(1'b0, 1'b1, 1'b0, 1'b0, "R8 start bit");
  endtask

  initial begin
    #(20 * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 ready in reset", s_ready, 1'b0);
    check("R1 busy in reset", busy_o, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 ready", s_ready, 1'b1);
    check("R1 sync", sync_o, 1'b0);
    check("R1 err", err_o, 1'b0);
    check("R1 busy", busy_o, 1'b0);
    for (int g = 0; g < 2; g++) begin
      gaps = (g == 1);
      for (int w = 1; w <= 53; w++) frame(w, 20, 2);
      for (int l = 1; l <= 30; l++) frame(3, l, 1);
      for (int h = 1; h <= 6; h++) frame(52, 16, h);
      for (int h = 1; h <= 6; h++) frame(1, 28, h);
    end
    gaps = 1'b0;
    // R10: error immediately followed by a frame at the limits
    frame(2, 5, 1);
    send(1'b1, 1'b0, 1'b0, 1'b1, "R10 restart");
    for (int i = 1; i <= 51; i++) send(1'b1, 1'b0, 1'b0, 1'b1, "R10 wait");
    for (int i = 1; i <= 28; i++) send(1'b0, 1'b0, 1'b0, 1'b1, "R10 low");
    for (int i = 1; i <= 4; i++) send(1'b1, 1'b0, 1'b0, 1'b1, "R10 high");
    send(1'b0, 1'b1, 1'b0, 1'b0, "R10 sync");
    @(negedge clk);
    @(posedge clk); #1;
    check("R9 sync single cycle", sync_o, 1'b0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule